// File: doc/BRIEF.md
# Dual-Enable Byte-Wide Static Memory Model with Activity Power State

This block is a clocked, synthesizable stand-in for an asynchronous byte-wide static memory of 8192 words. Every control pin is sampled on the rising clock edge. The block has two chip selects of opposite sense: `cs_n_i` is active low and `cs_i` is active high. It also has an active-low write strobe and an active-low output enable. Instead of a bidirectional pin, it drives a data-out bus and a separate data-out enable, so a surrounding design can build a three-state pad if it needs one. Reads and writes use the same bit polarity.

The block also keeps a power-state flag. Selected input activity raises the flag. It drops back to standby once a set number of clock cycles pass with no further activity. Power therefore follows the access rate, not how long the chip stays selected. The memory array is never cleared by deselection or standby.

The memory interface is a pin-level protocol, so it has no valid/ready handshake and no back-pressure. A sample is taken on every clock edge, and the caller must hold the pins for as long as it wants an operation to last.

Top module: `sram_emu`

## Requirements
- R1: A byte written to any address from 0 to 8191 is later read back with identical bits on `dout_o`.
- R2: When a sample has `cs_n_i`=0, `cs_i`=1, `we_n_i`=1 and `oe_n_i`=0 (and R5 suppression is not in force), the next cycle shows `doe_o`=1 and `dout_o` equal to the addressed byte.
- R3: When a sample has `cs_n_i`=1, `cs_i`=0, `oe_n_i`=1 or `we_n_i`=0, the next cycle shows `doe_o`=0 and `dout_o`=0.
- R4: The array changes only on a sample with `cs_n_i`=0, `cs_i`=1 and `we_n_i`=0 together, and that sample stores `din_i` at `addr_i`. Deasserting any one of the three signals stops the write.
- R5: If the sample at which both selects first become active already has `we_n_i`=0, then `doe_o` stays 0 until the chip is deselected, even if `we_n_i` returns high with `oe_n_i` low.
- R6: `pwr_active_o` is 1 in the cycle after any of these samples:
  - a rise of `cs_i` while `cs_n_i`=0;
  - a fall of `cs_n_i` while `cs_i`=1;
  - a fall of `we_n_i` while selected;
  - any `addr_i` change while selected;
  - any `din_i` change while selected with `we_n_i`=0.
- R7: Address or data changes while deselected, and data changes while selected with `we_n_i`=1, do not raise `pwr_active_o`.
- R8: After the last wake sample, `pwr_active_o` stays 1 for exactly TIMEOUT cycles (default 16) and then returns to 0.
- R9: Contents written before a deselected standby period read back unchanged after it.
- R10: During and just after reset, `doe_o`=0, `dout_o`=0 and `pwr_active_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| addr_i | input | 13 | Word address |
| din_i | input | 8 | Write data |
| cs_n_i | input | 1 | Chip select, active low |
| cs_i | input | 1 | Chip select, active high |
| we_n_i | input | 1 | Write strobe, active low |
| oe_n_i | input | 1 | Output enable, active low |
| dout_o | output | 8 | Read data, zero while not driven |
| doe_o | output | 1 | Data-out enable for an external pad |
| pwr_active_o | output | 1 | 1 = active power state, 0 = standby |

## Verification
There are three kinds of internal state, and each fails at the ports in its own way:
- A corrupted array word appears as a wrong `dout_o` byte one cycle after the next read of that address.
- A stuck write-entry suppression flag shows up as `doe_o` staying 0, or rising too early, one cycle after a read sample that follows a write-strobed selection.
- A wrong wake or countdown state shows up as `pwr_active_o` differing from the expected value on the cycle after a sample, or as an active window that is not exactly TIMEOUT cycles long.

The bench compares all three outputs against a bench model after every sample. This catches each such fault within one cycle of the first access that exposes it.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;

  // Access class of one sampled cycle
  typedef enum logic [1:0] {
    ACC_DESEL = 2'd0,   // at least one select inactive
    ACC_QUIET = 2'd1,   // selected, outputs held off
    ACC_READ  = 2'd2,   // selected, data driven
    ACC_WRITE = 2'd3    // selected, array written
  } access_e;

  // Sampled control pins, grouped
  typedef struct packed {
    logic cs_n;
    logic cs;
    logic we_n;
    logic oe_n;
  } ctrl_t;

endpackage

// File: rtl/sram_emu_decode.sv
module sram_emu_decode
  import sram_emu_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  ctrl_t   ctrl_i,
  output access_e acc_o,
  output logic    sel_o,
  output logic    wr_en_o,
  output logic    rd_en_o
);

  logic sel_now;
  logic sel_q;
  logic hold_off_q;
  logic hold_off_d;

  assign sel_now = ~ctrl_i.cs_n & ctrl_i.cs;

  // Entering selection with the write strobe already low keeps outputs off
  // until the next deselection.
  always_comb begin
    hold_off_d = hold_off_q;
    if (!sel_now) begin
      hold_off_d = 1'b0;
    end else if (!sel_q && !ctrl_i.we_n) begin
      hold_off_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sel_q      <= 1'b0;
      hold_off_q <= 1'b0;
    end else begin
      sel_q      <= sel_now;
      hold_off_q <= hold_off_d;
    end
  end

  always_comb begin
    if (!sel_now) begin
      acc_o = ACC_DESEL;
    end else if (!ctrl_i.we_n) begin
      acc_o = ACC_WRITE;
    end else if (!ctrl_i.oe_n && !hold_off_d) begin
      acc_o = ACC_READ;
    end else begin
      acc_o = ACC_QUIET;
    end
  end

  assign sel_o   = sel_now;
  assign wr_en_o = (acc_o == ACC_WRITE);
  assign rd_en_o = (acc_o == ACC_READ);

endmodule

// File: rtl/sram_emu_wake.sv
module sram_emu_wake
  import sram_emu_pkg::*;
#(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ctrl_t         ctrl_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] din_i,
  output logic          wake_o
);

  ctrl_t         ctrl_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] din_q;
  logic          sel_now;
  logic [4:0]    cause;

  assign sel_now = ~ctrl_i.cs_n & ctrl_i.cs;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ctrl_q <= '{cs_n: 1'b1, cs: 1'b0, we_n: 1'b1, oe_n: 1'b1};
      addr_q <= '0;
      din_q  <= '0;
    end else begin
      ctrl_q <= ctrl_i;
      addr_q <= addr_i;
      din_q  <= din_i;
    end
  end

  always_comb begin
    cause[0] = ctrl_i.cs & ~ctrl_q.cs & ~ctrl_i.cs_n;
    cause[1] = ~ctrl_i.cs_n & ctrl_q.cs_n & ctrl_i.cs;
    cause[2] = ~ctrl_i.we_n & ctrl_q.we_n & sel_now;
    cause[3] = (addr_i != addr_q) & sel_now;
    cause[4] = (din_i != din_q) & sel_now & ~ctrl_i.we_n;
  end

  assign wake_o = |cause;

endmodule

// File: rtl/sram_emu_pwr.sv
module sram_emu_pwr #(
  parameter int TIMEOUT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wake_i,
  output logic active_o
);

  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LOAD = CW'(TIMEOUT);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      left_q <= '0;
    end else if (wake_i) begin
      left_q <= LOAD;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign active_o = (left_q != '0);

endmodule

// File: rtl/sram_emu_array.sv
module sram_emu_array #(
  parameter int AW    = 13,
  parameter int DW    = 8,
  parameter int LANES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] din_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] dout_o,
  output logic          doe_o
);

  localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int RW   = (LANES > 1) ? AW - $clog2(LANES) : AW;
  localparam int ROWS = 1 << RW;

  logic [RW-1:0]  row;
  logic [LW-1:0]  lane;
  logic [DW-1:0]  lane_rd [LANES];
  logic [LW-1:0]  lane_q;
  logic           doe_q;

  generate
    if (LANES > 1) begin : g_split
      assign row  = addr_i[AW-1 -: RW];
      assign lane = addr_i[LW-1:0];
    end else begin : g_flat
      assign row  = addr_i;
      assign lane = '0;
    end
  endgenerate

  // One bank per byte lane, each written only when its lane is addressed
  for (genvar g = 0; g < LANES; g++) begin : g_bank
    logic [DW-1:0] bank [ROWS];
    logic          hit;

    assign hit = (lane == LW'(g));

    always_ff @(posedge clk_i) begin
      if (wr_en_i && hit) begin
        bank[row] <= din_i;
      end
    end

    always_ff @(posedge clk_i) begin
      if (rd_en_i) begin
        lane_rd[g] <= bank[row];
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      doe_q  <= 1'b0;
      lane_q <= '0;
    end else begin
      doe_q  <= rd_en_i;
      lane_q <= lane;
    end
  end

  assign doe_o  = doe_q;
  assign dout_o = doe_q ? lane_rd[lane_q] : '0;

endmodule

// File: rtl/sram_emu.sv
module sram_emu
  import sram_emu_pkg::*;
#(
  parameter int AW      = 13,
  parameter int DW      = 8,
  parameter int LANES   = 4,
  parameter int TIMEOUT = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] din_i,
  input  logic          cs_n_i,
  input  logic          cs_i,
  input  logic          we_n_i,
  input  logic          oe_n_i,
  output logic [DW-1:0] dout_o,
  output logic          doe_o,
  output logic          pwr_active_o
);

  ctrl_t   ctrl;
  access_e acc;
  logic    sel;
  logic    wr_en;
  logic    rd_en;
  logic    wake;

  assign ctrl = '{cs_n: cs_n_i, cs: cs_i, we_n: we_n_i, oe_n: oe_n_i};

  sram_emu_decode u_decode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctrl_i (ctrl),
    .acc_o  (acc),
    .sel_o  (sel),
    .wr_en_o(wr_en),
    .rd_en_o(rd_en)
  );

  sram_emu_wake #(.AW(AW), .DW(DW)) u_wake (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ctrl_i(ctrl),
    .addr_i(addr_i),
    .din_i (din_i),
    .wake_o(wake)
  );

  sram_emu_pwr #(.TIMEOUT(TIMEOUT)) u_pwr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wake_i  (wake),
    .active_o(pwr_active_o)
  );

  sram_emu_array #(.AW(AW), .DW(DW), .LANES(LANES)) u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_i),
    .din_i  (din_i),
    .wr_en_i(wr_en),
    .rd_en_i(rd_en),
    .dout_o (dout_o),
    .doe_o  (doe_o)
  );

endmodule

// File: rtl/sram_emu_chk.sv
module sram_emu_chk #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] din_i,
  input logic          cs_n_i,
  input logic          cs_i,
  input logic          we_n_i,
  input logic          oe_n_i,
  input logic [DW-1:0] dout_o,
  input logic          doe_o,
  input logic          pwr_active_o
);

  logic sel;
  assign sel = ~cs_n_i & cs_i;

  // R2: data is only driven after a read-mode sample
  p_read_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    doe_o |-> $past(sel && we_n_i && !oe_n_i));

  // R3: any disabling pin turns the outputs off next cycle
  p_out_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel || oe_n_i || !we_n_i) |=> (!doe_o && dout_o == '0));

  // R5: selection entered under a low write strobe gives no drive
  p_entry_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && sel && !$past(sel) && !we_n_i) |=> !doe_o);

  // R6: select edges wake the block
  p_wake_cs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && (($rose(cs_i) && !cs_n_i) || ($fell(cs_n_i) && cs_i)))
      |=> pwr_active_o);

  // R6: address movement while selected wakes the block
  p_wake_addr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && sel && !$stable(addr_i)) |=> pwr_active_o);

  // R8: with quiet inputs standby is kept
  p_stay_standby_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !pwr_active_o && $stable(addr_i) && $stable(din_i) &&
     $stable(cs_n_i) && $stable(cs_i) && $stable(we_n_i)) |=> !pwr_active_o);

endmodule

bind sram_emu sram_emu_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .din_i       (din_i),
  .cs_n_i      (cs_n_i),
  .cs_i        (cs_i),
  .we_n_i      (we_n_i),
  .oe_n_i      (oe_n_i),
  .dout_o      (dout_o),
  .doe_o       (doe_o),
  .pwr_active_o(pwr_active_o)
);

// File: tb/sram_emu_tb_top.sv
module sram_emu_tb_top;

  localparam int AW    = 13;
  localparam int DW    = 8;
  localparam int TO    = 16;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic          cs_n, cs, we_n, oe_n;
  logic [DW-1:0] dout;
  logic          doe, act;

  always #4 clk = ~clk;

  sram_emu #(.AW(AW), .DW(DW), .LANES(4), .TIMEOUT(TO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .din_i(din),
    .cs_n_i(cs_n), .cs_i(cs), .we_n_i(we_n), .oe_n_i(oe_n),
    .dout_o(dout), .doe_o(doe), .pwr_active_o(act)
  );

  int n_chk = 0;
  int n_bad = 0;

  // bench reference state
  logic [DW-1:0] m_mem [WORDS];
  logic          p_csn = 1'b1, p_cs = 1'b0, p_wen = 1'b1, p_sel = 1'b0;
  logic [AW-1:0] p_a = '0;
  logic [DW-1:0] p_d = '0;
  logic          m_flag = 1'b0;
  int            m_cnt = 0;
  logic          e_doe = 1'b0;
  logic [DW-1:0] e_dout = '0;
  logic          m_wake = 1'b0;
  logic          m_supp = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int actual, input int expected);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, actual, expected);
    end
  endtask

  function automatic logic [DW-1:0] pattern(input int a);
    return DW'((a * 7 + 3) ^ (a >> 8));
  endfunction

  task automatic step(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic csn, input logic c, input logic wen,
                      input logic oen);
    logic sel_n;
    @(negedge clk);
    addr = a; din = d; cs_n = csn; cs = c; we_n = wen; oe_n = oen;
    @(posedge clk);
    sel_n  = !csn && c;
    m_wake = (c && !p_cs && !csn) || (!csn && p_csn && c) ||
             (!wen && p_wen && sel_n) || ((a != p_a) && sel_n) ||
             ((d != p_d) && sel_n && !wen);
    if (!sel_n) m_flag = 1'b0;
    else if (!p_sel && !wen) m_flag = 1'b1;
    m_supp = sel_n && wen && !oen && m_flag;
    e_doe  = sel_n && wen && !oen && !m_flag;
    e_dout = e_doe ? m_mem[a] : '0;
    if (sel_n && !wen) m_mem[a] = d;
    if (m_wake) m_cnt = TO;
    else if (m_cnt > 0) m_cnt--;
    p_csn = csn; p_cs = c; p_wen = wen; p_a = a; p_d = d; p_sel = sel_n;
    #2;
    check(doe == e_doe, e_doe ? "R2" : (m_supp ? "R5" : "R3"), "doe",
          int'(doe), int'(e_doe));
    check(dout == e_dout, e_doe ? "R1" : "R3", "dout", int'(dout), int'(e_dout));
    check(act == (m_cnt != 0), m_wake ? "R6" : "R8", "active",
          int'(act), int'(m_cnt != 0));
  endtask

  // deselected, all pins stable, until standby
  task automatic drain(input logic [AW-1:0] a);
    for (int i = 0; i < TO + 2; i++) step(a, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int active_len;
    void'($urandom(32'h5eed_c0de));
    rst_n = 1'b0; addr = '0; din = '0; cs_n = 1'b1; cs = 1'b0; we_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check(doe == 1'b0 && dout == '0, "R10", "reset outputs", {doe, dout}, 0);
    check(act == 1'b0, "R10", "reset power", int'(act), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    check(act == 1'b0 && doe == 1'b0, "R10", "after reset", {act, doe}, 0);

    // fill the array, then a few boundary writes (R1, R4)
    for (int a = 0; a < WORDS; a++) step(AW'(a), pattern(a), 1'b0, 1'b1, 1'b0, 1'b1);
    step(AW'(WORDS - 1), 8'hA5, 1'b0, 1'b1, 1'b0, 1'b1);
    step(AW'(0), 8'h5A, 1'b0, 1'b1, 1'b0, 1'b1);
    step(AW'(0), 8'h5A, 1'b1, 1'b1, 1'b1, 1'b1);
    step(AW'(WORDS - 1), 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
    check(doe && dout == 8'hA5, "R1", "top word", int'(dout), 'hA5);
    step(AW'(0), 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
    check(doe && dout == 8'h5A, "R1", "bottom word", int'(dout), 'h5A);

    // R3: each disabling pin
    step(AW'(0), 8'h00, 1'b1, 1'b1, 1'b1, 1'b0);
    check(!doe && dout == '0, "R3", "cs_n high", int'(doe), 0);
    step(AW'(0), 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    check(!doe && dout == '0, "R3", "cs low", int'(doe), 0);
    step(AW'(0), 8'h00, 1'b0, 1'b1, 1'b1, 1'b1);
    check(!doe && dout == '0, "R3", "oe_n high", int'(doe), 0);
    step(AW'(0), 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    check(!doe && dout == '0, "R3", "we_n low", int'(doe), 0);

    // R4: gated write attempts leave word 5 untouched
    step(AW'(5), 8'h3C, 1'b0, 1'b1, 1'b0, 1'b1);
    step(AW'(5), 8'hFF, 1'b1, 1'b1, 1'b0, 1'b1);
    step(AW'(5), 8'hEE, 1'b0, 1'b0, 1'b0, 1'b1);
    step(AW'(5), 8'hDD, 1'b0, 1'b1, 1'b1, 1'b1);
    step(AW'(5), 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
    check(doe && dout == 8'h3C, "R4", "gated writes", int'(dout), 'h3C);

    // R5: select entered with write strobe low
    step(AW'(9), 8'h77, 1'b1, 1'b1, 1'b0, 1'b0);
    step(AW'(9), 8'h77, 1'b0, 1'b1, 1'b0, 1'b0);
    step(AW'(9), 8'h77, 1'b0, 1'b1, 1'b1, 1'b0);
    check(!doe, "R5", "suppressed read", int'(doe), 0);
    step(AW'(9), 8'h77, 1'b0, 1'b1, 1'b1, 1'b0);
    check(!doe, "R5", "still suppressed", int'(doe), 0);
    step(AW'(9), 8'h77, 1'b1, 1'b1, 1'b1, 1'b0);
    step(AW'(9), 8'h77, 1'b0, 1'b1, 1'b1, 1'b0);
    check(doe && dout == 8'h77, "R5", "released after deselect", int'(dout), 'h77);

    // R7: activity that must not wake
    drain(AW'(9));
    for (int i = 0; i < 6; i++) step(AW'(i * 100), DW'(i * 3 + 1), 1'b1, 1'b1, 1'b0, 1'b1);
    check(!act, "R7", "deselected address/data motion", int'(act), 0);
    step(AW'(9), 8'h00, 1'b0, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < TO + 2; i++) step(AW'(9), 8'h00, 1'b0, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 6; i++) step(AW'(9), DW'(i + 40), 1'b0, 1'b1, 1'b1, 1'b1);
    check(!act, "R7", "data motion with we_n high", int'(act), 0);

    // R8: one wake gives exactly TO active cycles; R6: select edge wakes
    drain(AW'(9));
    step(AW'(9), 8'h00, 1'b0, 1'b1, 1'b1, 1'b1);
    check(act, "R6", "cs_n fall wakes", int'(act), 1);
    active_len = act ? 1 : 0;
    for (int i = 0; i < TO + 3; i++) begin
      step(AW'(9), 8'h00, 1'b0, 1'b1, 1'b1, 1'b1);
      if (act) active_len++;
    end
    check(active_len == TO, "R8", "active length", active_len, TO);
    step(AW'(10), 8'h00, 1'b0, 1'b1, 1'b1, 1'b1);
    check(act, "R6", "address change wakes", int'(act), 1);

    // R9: after standby, earlier contents intact
    drain(AW'(0));
    step(AW'(1234), 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
    check(doe && dout == pattern(1234), "R9", "retained word", int'(dout),
          int'(pattern(1234)));

    // random mixed traffic against the reference
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] a;
      logic          csn, c, wen, oen;
      a   = ($urandom % 2) ? AW'($urandom % 16) : AW'($urandom);
      csn = ($urandom % 8) == 0;
      c   = ($urandom % 8) != 0;
      wen = ($urandom % 3) == 0;
      oen = ($urandom % 4) == 0;
      step(a, DW'($urandom), csn, c, wen, oen);
      if (($urandom % 40) == 0) begin
        for (int k = 0; k < TO + 4; k++) step(a, din, csn, c, 1'b1, oen);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule